// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block moves a group of processor registers to or from a byte-wide stack in memory. A single start command carries three things: an operation code, a choice between the system stack and the user stack, and an eight-bit register-select mask. The block then moves one byte per clock cycle through a simple memory port and walks the selected stack pointer. When a push is running, register bytes are read from the register-file inputs. When a pull is running, each byte read from memory appears on a register-file write port, together with the register's identity and which half of the register it is.

The return-from-interrupt operation always runs on the system stack. It first restores the flag byte. Bit 7 of that byte then decides whether the rest of the saved machine state follows, or only the program counter. When the block finishes, it reports the final value of the stack pointer it used. The surrounding core then writes that value back. The core also does all opcode decode and all interrupt handling.

Top module: `pp_stack_seq`

## Requirements
- R1: A push writes each byte at SP-1 and then uses that address as the new SP. The stack pointer reported at the end equals the start value minus the number of bytes written.
- R2: A pull reads each byte at SP and then increments SP. The reported end value equals the start value plus the number of bytes read. Register writes (`rf_we`) occur only during pull transfers.
- R3: The mask bit to register mapping is: bit0 flags, bit1 A, bit2 B, bit3 page register, bit4 X, bit5 Y, bit6 the other stack pointer, bit7 PC.
- R3 (continued): `rf_id` codes are 0 flags, 1 A, 2 B, 3 page register, 4 X, 5 Y, 6 U, 7 S, 8 PC.
- R4: A push visits the selected registers from bit7 down to bit0, so the flags byte ends at the lowest address. A pull visits them from bit0 up to bit7.
- R5: Each 16-bit register is stored with its high byte at the lower address. A push moves the low byte first and a pull moves the high byte first. `rf_hi` is 1 for a high byte and 0 for a low byte or an 8-bit register.
- R6: Mask bit6 selects U when the system stack is in use and S when the user stack is in use. A push reads that register and a pull writes it.
- R7: `op` 0 means push and 1 means pull. For `op` 2, the return-from-interrupt operation, `use_u` and `mask` are ignored. The flags byte is pulled from S first. If its bit7 is 1, A, B, the page register, X, Y, U and PC follow in that order. If bit7 is 0, only PC follows.
- R8: Mask bits that are 0 take no cycle. Transfers run on consecutive cycles.
- R9: `busy` rises in the cycle after an accepted start and stays high through the last transfer. `done` is a one-cycle pulse in the following cycle, and `sp_we` carries the final SP in that same cycle.
- R10: A push or pull with an all-zero mask makes no transfer. It raises `done` in the cycle after the start, and reports the unchanged SP.
- R11: A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command, accepted when not busy |
| op | input | 2 | 0 push, 1 pull, 2 return-from-interrupt |
| use_u | input | 1 | 1 selects the user stack (push/pull only) |
| mask | input | 8 | Register-select mask |
| reg_cc | input | 8 | Flags register value |
| reg_a | input | 8 | Accumulator A value |
| reg_b | input | 8 | Accumulator B value |
| reg_dp | input | 8 | Page register value |
| reg_x | input | 16 | Index X value |
| reg_y | input | 16 | Index Y value |
| reg_u | input | 16 | User stack pointer value |
| reg_s | input | 16 | System stack pointer value |
| reg_pc | input | 16 | Program counter value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| rf_we | output | 1 | Register-file byte write strobe |
| rf_id | output | 4 | Register being moved (R3 codes) |
| rf_hi | output | 1 | Byte is the high half of a 16-bit register |
| rf_wdata | output | 8 | Register-file write data |
| sp_we | output | 1 | Final stack pointer valid |
| sp_sel_u | output | 1 | Final value belongs to U (else S) |
| sp_wdata | output | 16 | Final stack pointer value |

## Verification
The bench checks the order and the byte halves of a full-mask push and the matching pull. A design that reversed the walk, or stored 16-bit registers with the low byte at the lower address, would show wrong addresses or data as soon as the first wide register moves.

It also checks the stack-pointer slot from both stacks. A swap error would label a transfer U where S was expected. Both values of the stacked flag bit in return-from-interrupt are covered: a wrong decision would restore six registers too many or too few, and the transfer count would show it.

Three more cases are covered: an empty mask, which would stall or move the pointer if handled wrongly; a sparse mask, which would waste cycles if zero bits were not skipped; and a start issued mid-sequence, which would restart the walk if it were not ignored.

// File: rtl/pp_stack_pkg.sv
// Shared definitions for the stack push/pull sequencer.
// Assumes an eight-slot register-select mask with 16-bit registers in the top half.
package pp_stack_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_PULL = 2'd1,
        OP_RTI  = 2'd2,
        OP_RSVD = 2'd3
    } stk_op_e;

    typedef enum logic [3:0] {
        RID_CC = 4'd0,
        RID_A  = 4'd1,
        RID_B  = 4'd2,
        RID_DP = 4'd3,
        RID_X  = 4'd4,
        RID_Y  = 4'd5,
        RID_U  = 4'd6,
        RID_S  = 4'd7,
        RID_PC = 4'd8
    } reg_id_e;

    localparam int unsigned NSLOT      = 8;
    localparam int unsigned SLOT_W     = $clog2(NSLOT);
    localparam int unsigned FIRST_WIDE = 4;

endpackage

// File: rtl/pp_slot_pick.sv
// Priority pick of the next register slot from a pending mask.
// from_top=1 picks the highest set bit (push order).
// from_top=0 picks the lowest set bit (pull order).
// The result is meaningless for an empty mask; the caller never uses it then.
module pp_slot_pick #(
    parameter  int unsigned N  = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic          from_top,
    output logic [IW-1:0] idx
);

    logic [N-1:0]  scan;
    logic [IW-1:0] pos;

    // Mirror the mask when scanning from the top, so one low-first search serves both orders.
    for (genvar g = 0; g < N; g++) begin : g_mirror
        assign scan[g] = from_top ? mask[N-1-g] : mask[g];
    end

    // Find the lowest set bit of the scan vector.
    always_comb begin
        pos = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (scan[i]) pos = IW'(i);
        end
    end

    // Map the position back to a slot index.
    assign idx = from_top ? IW'(N - 1) - pos : pos;

endmodule

// File: rtl/pp_sp_unit.sv
// Working stack pointer.
// Loaded at start, then stepped by one per transfer.
// Pushing presents SP-1 (pre-decrement); pulling presents SP (post-increment).
module pp_sp_unit #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] addr
);

    // Hold or advance the working pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (load) sp <= load_val;
        else if (step) sp <= down ? sp - AW'(1) : sp + AW'(1);
    end

    // Bus address for the current transfer.
    assign addr = down ? sp - AW'(1) : sp;

endmodule

// File: rtl/pp_byte_src.sv
// Maps a slot and byte half to a register identity and a source byte for pushes.
// Assumes slots 0..3 are 8-bit and slots 4..7 are 16-bit.
// Slot 6 names whichever stack pointer is not in use.
module pp_byte_src #(
    parameter  int unsigned DW = 8,
    localparam int unsigned WW = 2 * DW
) (
    input  logic [2:0]    slot,
    input  logic          hi,
    input  logic          use_u,
    input  logic [DW-1:0] reg_cc,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] reg_b,
    input  logic [DW-1:0] reg_dp,
    input  logic [WW-1:0] reg_x,
    input  logic [WW-1:0] reg_y,
    input  logic [WW-1:0] reg_u,
    input  logic [WW-1:0] reg_s,
    input  logic [WW-1:0] reg_pc,
    output logic [DW-1:0] byte_o,
    output logic [3:0]    id_o
);
    import pp_stack_pkg::*;

    logic [WW-1:0] wide_val;

    // Select the 16-bit register of a wide slot.
    always_comb begin
        case (slot)
            3'd4:    wide_val = reg_x;
            3'd5:    wide_val = reg_y;
            3'd6:    wide_val = use_u ? reg_s : reg_u;
            default: wide_val = reg_pc;
        endcase
    end

    // Select the byte to place on the bus.
    always_comb begin
        case (slot)
            3'd0:    byte_o = reg_cc;
            3'd1:    byte_o = reg_a;
            3'd2:    byte_o = reg_b;
            3'd3:    byte_o = reg_dp;
            default: byte_o = hi ? wide_val[WW-1:DW] : wide_val[DW-1:0];
        endcase
    end

    // Report which register the slot stands for.
    always_comb begin
        case (slot)
            3'd0:    id_o = RID_CC;
            3'd1:    id_o = RID_A;
            3'd2:    id_o = RID_B;
            3'd3:    id_o = RID_DP;
            3'd4:    id_o = RID_X;
            3'd5:    id_o = RID_Y;
            3'd6:    id_o = use_u ? RID_S : RID_U;
            default: id_o = RID_PC;
        endcase
    end

endmodule

// File: rtl/pp_stack_seq.sv
// Stack push/pull sequencer top.
// Runs one byte transfer per cycle over a memory port whose read data is valid
// in the same cycle as the address.
// Pull results go to the register-file write port; the final SP is reported with done.
// A start is accepted only while idle.
module pp_stack_seq #(
    parameter  int unsigned DW = 8,
    localparam int unsigned WW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          use_u,
    input  logic [7:0]    mask,
    input  logic [DW-1:0] reg_cc,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] reg_b,
    input  logic [DW-1:0] reg_dp,
    input  logic [WW-1:0] reg_x,
    input  logic [WW-1:0] reg_y,
    input  logic [WW-1:0] reg_u,
    input  logic [WW-1:0] reg_s,
    input  logic [WW-1:0] reg_pc,
    output logic          busy,
    output logic          done,
    output logic [WW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          rf_we,
    output logic [3:0]    rf_id,
    output logic          rf_hi,
    output logic [DW-1:0] rf_wdata,
    output logic          sp_we,
    output logic          sp_sel_u,
    output logic [WW-1:0] sp_wdata
);
    import pp_stack_pkg::*;

    logic              busy_q, done_q, half_q, pull_q, rti_q, use_u_q;
    logic [NSLOT-1:0]  mask_q, mask_clr, mask_nxt;
    logic [SLOT_W-1:0] slot;
    logic              wide, is_hi, finish_slot, last, start_ok, is_rti_cmd;
    logic [WW-1:0]     sp_cur, sp_load;

    assign start_ok   = start && !busy_q;
    assign is_rti_cmd = (op == OP_RTI);

    pp_slot_pick #(.N(NSLOT)) u_pick (
        .mask     (mask_q),
        .from_top (!pull_q),
        .idx      (slot)
    );

    // Decode the current byte: wide slot, which half, and whether the slot completes.
    assign wide        = (slot >= SLOT_W'(FIRST_WIDE));
    assign is_hi       = wide && (pull_q ? !half_q : half_q);
    assign finish_slot = !wide || half_q;

    // Pending mask after this slot; the RTI flag byte widens the frame on its stacked bit.
    always_comb begin
        mask_clr = mask_q & ~(NSLOT'(1) << slot);
        if (rti_q && slot == '0)
            mask_nxt = mem_rdata[DW-1] ? 8'hFE : 8'h80;
        else
            mask_nxt = mask_clr;
    end

    assign last = busy_q && finish_slot && (mask_nxt == '0);

    // Sequencer control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            half_q  <= 1'b0;
            pull_q  <= 1'b0;
            rti_q   <= 1'b0;
            use_u_q <= 1'b0;
            mask_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_ok) begin
                pull_q  <= (op != OP_PUSH);
                rti_q   <= is_rti_cmd;
                use_u_q <= is_rti_cmd ? 1'b0 : use_u;
                mask_q  <= is_rti_cmd ? 8'h01 : mask;
                half_q  <= 1'b0;
                if (!is_rti_cmd && mask == '0) done_q <= 1'b1;
                else                           busy_q <= 1'b1;
            end else if (busy_q) begin
                half_q <= wide && !half_q;
                if (finish_slot) mask_q <= mask_nxt;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign sp_load = (!is_rti_cmd && use_u) ? reg_u : reg_s;

    pp_sp_unit #(.AW(WW)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (sp_load),
        .step     (busy_q),
        .down     (!pull_q),
        .sp       (sp_cur),
        .addr     (mem_addr)
    );

    pp_byte_src #(.DW(DW)) u_src (
        .slot   (slot),
        .hi     (is_hi),
        .use_u  (use_u_q),
        .reg_cc (reg_cc),
        .reg_a  (reg_a),
        .reg_b  (reg_b),
        .reg_dp (reg_dp),
        .reg_x  (reg_x),
        .reg_y  (reg_y),
        .reg_u  (reg_u),
        .reg_s  (reg_s),
        .reg_pc (reg_pc),
        .byte_o (mem_wdata),
        .id_o   (rf_id)
    );

    assign busy     = busy_q;
    assign done     = done_q;
    assign mem_we   = busy_q && !pull_q;
    assign mem_re   = busy_q && pull_q;
    assign rf_we    = busy_q && pull_q;
    assign rf_hi    = is_hi;
    assign rf_wdata = mem_rdata;
    assign sp_we    = done_q;
    assign sp_sel_u = use_u_q;
    assign sp_wdata = sp_cur;

endmodule

// File: rtl/pp_stack_seq_chk.sv
// Protocol checker for pp_stack_seq, attached with bind.
// Assumes the port meanings given in the brief.
module pp_stack_seq_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op,
    input logic [7:0]    mask,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          rf_we
);

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (op == 2'd2 || mask != 8'h00)) |=> busy);

    p_empty_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'd2 && mask == 8'h00) |=> (done && !busy));

    p_we_re_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_push_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

    p_pull_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    p_rf_pull_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_re);

endmodule

bind pp_stack_seq pp_stack_seq_chk #(.AW(2 * DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .mask     (mask),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .rf_we    (rf_we)
);

// File: tb/pp_stack_seq_tb_top.sv
`timescale 1ns/1ps
module pp_stack_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        use_u_i = 1'b0;
    logic [7:0]  mask_i = 8'h00;
    logic [7:0]  rcc = 8'h00, ra = 8'h00, rb = 8'h00, rdp = 8'h00;
    logic [15:0] rx = 16'h0, ry = 16'h0, ru = 16'h0, rs = 16'h0, rpc = 16'h0;
    logic        busy, done, mem_we, mem_re, rf_we, rf_hi, sp_we, sp_sel_u;
    logic [15:0] mem_addr, sp_wdata;
    logic [7:0]  mem_wdata, mem_rdata, rf_wdata;
    logic [3:0]  rf_id;

    always #2.5 clk = ~clk;

    pp_stack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .use_u(use_u_i), .mask(mask_i),
        .reg_cc(rcc), .reg_a(ra), .reg_b(rb), .reg_dp(rdp),
        .reg_x(rx), .reg_y(ry), .reg_u(ru), .reg_s(rs), .reg_pc(rpc),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_id(rf_id),
        .rf_hi(rf_hi), .rf_wdata(rf_wdata), .sp_we(sp_we), .sp_sel_u(sp_sel_u),
        .sp_wdata(sp_wdata)
    );

    // Byte memory model with same-cycle read data.
    logic [7:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [3:0]  id;
        logic        hi;
        logic [3:0]  req;
    } ev_t;

    ev_t q[$];
    int  n_chk = 0;
    int  n_bad = 0;
    logic [15:0] exp_sp;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected transfer per bus cycle and compare.
    always @(negedge clk) begin
        if (rst_n && busy && (mem_we || mem_re)) begin
            logic [7:0] d;
            ev_t e;
            d = mem_we ? mem_wdata : rf_wdata;
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected transfer actual=%h expected=none", mem_addr);
            end else begin
                e = q.pop_front();
                if (mem_we !== e.we || mem_addr !== e.addr || d !== e.data ||
                    rf_id !== e.id || rf_hi !== e.hi || rf_we !== !e.we) begin
                    n_bad++;
                    $display("FAIL R%0d actual we=%b addr=%h data=%h id=%0d hi=%b expected we=%b addr=%h data=%h id=%0d hi=%b",
                             e.req, mem_we, mem_addr, d, rf_id, rf_hi, e.we, e.addr, e.data, e.id, e.hi);
                end
            end
        end
    end

    // R3/R6 encoding: slot to register id.
    function automatic logic [3:0] id_of(input int slot, input bit uu);
        case (slot)
            0: return 4'd0;
            1: return 4'd1;
            2: return 4'd2;
            3: return 4'd3;
            4: return 4'd4;
            5: return 4'd5;
            6: return uu ? 4'd7 : 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [15:0] wide_of(input int slot, input bit uu);
        case (slot)
            4: return rx;
            5: return ry;
            6: return uu ? rs : ru;
            default: return rpc;
        endcase
    endfunction

    function automatic logic [7:0] narrow_of(input int slot);
        case (slot)
            0: return rcc;
            1: return ra;
            2: return rb;
            default: return rdp;
        endcase
    endfunction

    task automatic add(input bit we, input logic [15:0] a, input logic [7:0] d,
                       input logic [3:0] id, input bit hi, input int req);
        ev_t e;
        e.we = we; e.addr = a; e.data = d; e.id = id; e.hi = hi; e.req = 4'(req);
        q.push_back(e);
    endtask

    // Expected push: bit7 down to bit0, SP-1 before each byte, low byte first (R1 R4 R5).
    task automatic exp_push(input logic [7:0] m, input bit uu, input int req);
        logic [15:0] sp;
        sp = uu ? ru : rs;
        for (int s = 7; s >= 0; s--) begin
            if (m[s]) begin
                if (s >= 4) begin
                    sp = sp - 16'd1; add(1'b1, sp, wide_of(s, uu)[7:0],  id_of(s, uu), 1'b0, req);
                    sp = sp - 16'd1; add(1'b1, sp, wide_of(s, uu)[15:8], id_of(s, uu), 1'b1, req);
                end else begin
                    sp = sp - 16'd1; add(1'b1, sp, narrow_of(s), id_of(s, uu), 1'b0, req);
                end
            end
        end
        exp_sp = sp;
    endtask

    // Expected pull walk: bit0 up to bit7, read at SP then +1, high byte first (R2 R4 R5).
    task automatic walk_pull(input logic [7:0] m, input bit uu, input int req, inout logic [15:0] sp);
        for (int s = 0; s < 8; s++) begin
            if (m[s]) begin
                if (s >= 4) begin
                    add(1'b0, sp, mem[sp[7:0]], id_of(s, uu), 1'b1, req); sp = sp + 16'd1;
                    add(1'b0, sp, mem[sp[7:0]], id_of(s, uu), 1'b0, req); sp = sp + 16'd1;
                end else begin
                    add(1'b0, sp, mem[sp[7:0]], id_of(s, uu), 1'b0, req); sp = sp + 16'd1;
                end
            end
        end
    endtask

    task automatic exp_pull(input logic [7:0] m, input bit uu, input int req);
        logic [15:0] sp;
        sp = uu ? ru : rs;
        walk_pull(m, uu, req, sp);
        exp_sp = sp;
    endtask

    // Expected return-from-interrupt on S (R7).
    task automatic exp_rti();
        logic [15:0] sp;
        logic [7:0]  f;
        sp = rs;
        f = mem[sp[7:0]];
        walk_pull(8'h01, 1'b0, 7, sp);
        walk_pull(f[7] ? 8'hFE : 8'h80, 1'b0, 7, sp);
        exp_sp = sp;
    endtask

    // Issue one command, wait for done and check timing and the final SP (R9).
    task automatic run(input logic [1:0] o, input bit uu, input logic [7:0] m, input bit inject, input string tag);
        int nbytes;
        int cyc;
        bit sel_u;
        nbytes = q.size();
        sel_u  = (o == 2'd2) ? 1'b0 : uu;
        @(negedge clk);
        start = 1'b1; op_i = o; use_u_i = uu; mask_i = m;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (nbytes > 0) chk(busy === 1'b1, {"R9 busy after start ", tag}, 32'(busy), 32'd1);
        while (!done && cyc < 300) begin
            start = inject && (cyc == 2);
            if (start) begin op_i = 2'd0; mask_i = 8'hFF; use_u_i = 1'b1; end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == nbytes + 1, {"R8 R9 cycles to done ", tag}, 32'(cyc), 32'(nbytes + 1));
        chk(sp_we === 1'b1 && busy === 1'b0, {"R9 sp_we with done ", tag}, {30'd0, sp_we, busy}, 32'h2);
        chk(sp_wdata === exp_sp, {"R1 R2 final SP ", tag}, 32'(sp_wdata), 32'(exp_sp));
        chk(sp_sel_u === sel_u, {"R6 R7 stack select ", tag}, 32'(sp_sel_u), 32'(sel_u));
        chk(q.size() == 0, {"R8 missing transfers ", tag}, 32'(q.size()), 32'd0);
        q.delete();
        if (sel_u) ru = exp_sp; else rs = exp_sp;
        @(negedge clk);
        chk(done === 1'b0, {"R9 done single pulse ", tag}, 32'(done), 32'd0);
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                chk(busy === 1'b0, "R11 ignored start left no work", 32'(busy), 32'd0);
                @(negedge clk);
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy === 1'b0 && done === 1'b0, "R9 reset idle", {30'd0, busy, done}, 32'd0);
        chk(mem_we === 1'b0 && mem_re === 1'b0, "R9 reset no bus", {30'd0, mem_we, mem_re}, 32'd0);
        rst_n = 1'b1;

        ra = 8'h11; rb = 8'h22; rdp = 8'h33; rcc = 8'h84;
        rx = 16'h4455; ry = 16'h6677; ru = 16'h0060; rs = 16'h00C0; rpc = 16'hA1B2;

        // R1 R3 R4 R5 R6: full push on S
        exp_push(8'hFF, 1'b0, 4); run(2'd0, 1'b0, 8'hFF, 1'b0, "push S all");
        // R2 R4: full pull on S restores the same bytes
        ra = 8'hEE; rx = 16'hDEAD;
        exp_pull(8'hFF, 1'b0, 2); run(2'd1, 1'b0, 8'hFF, 1'b0, "pull S all");
        // R6: other stack pointer from the user stack is S
        exp_push(8'h40, 1'b1, 6); run(2'd0, 1'b1, 8'h40, 1'b0, "push U slot6");
        exp_pull(8'h40, 1'b1, 6); run(2'd1, 1'b1, 8'h40, 1'b0, "pull U slot6");
        // R8: sparse mask, no idle cycles
        exp_push(8'h95, 1'b0, 8); run(2'd0, 1'b0, 8'h95, 1'b0, "push sparse");
        exp_pull(8'h95, 1'b0, 8); run(2'd1, 1'b0, 8'h95, 1'b0, "pull sparse");
        // R10: empty mask both ways
        exp_sp = rs; run(2'd0, 1'b0, 8'h00, 1'b0, "push empty R10");
        exp_sp = ru; run(2'd1, 1'b1, 8'h00, 1'b0, "pull empty R10");
        // R7: full frame when the stacked flag bit7 is 1; use_u and mask ignored
        rcc = 8'h84;
        exp_push(8'hFF, 1'b0, 7); run(2'd0, 1'b0, 8'hFF, 1'b0, "push frame E1");
        exp_rti(); run(2'd2, 1'b1, 8'h00, 1'b0, "rti E1 R7");
        // R7: short frame when bit7 is 0
        rcc = 8'h04;
        exp_push(8'h81, 1'b0, 7); run(2'd0, 1'b0, 8'h81, 1'b0, "push frame E0");
        exp_rti(); run(2'd2, 1'b0, 8'h3C, 1'b0, "rti E0 R7");
        // R11: a second start mid-sequence is ignored
        exp_push(8'h30, 1'b0, 11); run(2'd0, 1'b0, 8'h30, 1'b1, "push inject R11");
        exp_pull(8'h30, 1'b0, 11); run(2'd1, 1'b0, 8'h30, 1'b0, "pull back R11");
        summary();
    end

endmodule